// File: doc/BRIEF.md
# Fixed-Point Ray-Triangle Intersection Unit

The unit takes one ray and one triangle per request and decides whether the ray strikes the triangle before the ray's current nearest distance. It does so in three ordered phases. The first finds where the ray crosses the triangle's supporting plane. The second checks whether that crossing lies inside the triangle, using barycentric weights. The third divides out the hit distance and the two barycentric weights. A request rejected by either of the first two phases is reported as a miss at once. It never reaches the divider stage, and it asks for nothing more.

The triangle is given as one vertex and two edge vectors. The plane normal is formed inside the unit as the cross product of the edges. The first two phases run on a single shared three-term dot-product datapath, one product sum per cycle. The hit-point stage has its own dividers, and it works on a hit while the next request is already entering the plane test. All arithmetic is exact two's-complement integer math. The results carry `FRAC_W` fractional bits, and each result carries the request's tag.

Top module: `tri_isect`

## Requirements
- R1: A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the cycle after a request is taken, and it stays low while the shared plane/barycentric datapath is working on that request.
- R2: After reset, `in_ready` is 1 and `out_valid` is 0.
- R3: A ray whose direction is parallel to the triangle's plane (n·D = 0, with n = e1 × e2) is reported as a miss with `out_phase` = 1.
- R4: Let t = n·(v0−O) / n·D. The request is a phase-1 miss (`out_phase` = 1) when t < 0 or t ≥ `in_tmax`. A crossing at exactly t = 0 is accepted.
- R5: Let u and v be the barycentric weights of the crossing point along e1 and e2. The request is a phase-2 miss (`out_phase` = 2) when u < 0, v < 0 or u + v > 1. Points exactly on an edge or vertex (u = 0, v = 0 or u + v = 1) count as hits.
- R6: A hit reports `out_hit` = 1 and `out_phase` = 3. It gives `out_t` = floor(t·2^FRAC_W), `out_u` = floor(u·2^FRAC_W) and `out_v` = floor(v·2^FRAC_W). A negative n·D gives the same result as the mirrored positive case.
- R7: Counted in rising edges after the accepting edge, the result appears after edge 2 for a phase-1 miss, after edge 5 for a phase-2 miss, and after edge 6 for a hit. `out_valid` is high for exactly one cycle per request.
- R8: For a request that passes phase 1, `in_ready` is high again after edge 5. A following request may be taken on the same edge that delivers the earlier hit. Results never occupy two consecutive cycles.
- R9: Every result carries the tag of its request. A miss reports `out_hit` = 0 and `out_t`, `out_u` and `out_v` all zero.
- R10: Each three-vector input (`in_org`, `in_dir`, `in_v0`, `in_e1`, `in_e2`) packs x in bits COORD_W−1:0, y in the next COORD_W bits, and z in the top COORD_W bits, each in two's complement. `in_tmax` is an unsigned integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_tag | input | TAG_W | Request identifier |
| in_org | input | 3*COORD_W | Ray origin |
| in_dir | input | 3*COORD_W | Ray direction |
| in_tmax | input | COORD_W | Current nearest distance (exclusive bound) |
| in_v0 | input | 3*COORD_W | Triangle base vertex |
| in_e1 | input | 3*COORD_W | Edge from v0 to the second vertex |
| in_e2 | input | 3*COORD_W | Edge from v0 to the third vertex |
| out_valid | output | 1 | Result present (one-cycle pulse) |
| out_tag | output | TAG_W | Tag of the reported request |
| out_hit | output | 1 | 1 for a hit, 0 for a miss |
| out_phase | output | 2 | 1 plane miss, 2 barycentric miss, 3 hit |
| out_t | output | COORD_W+FRAC_W | Hit distance, FRAC_W fraction bits |
| out_u | output | FRAC_W+1 | Weight along e1, FRAC_W fraction bits |
| out_v | output | FRAC_W+1 | Weight along e2, FRAC_W fraction bits |

## Verification
The bench aims at the boundaries of each rejection rule:
- a ray lying in the plane;
- a crossing behind the origin;
- a crossing exactly at the distance bound;
- a crossing exactly at the origin;
- crossings exactly on each edge and on a vertex.

A design that uses the wrong comparison at the distance bound or at the triangle's edges flips these cases between hit and miss. A design that mishandles the sign of n·D drops or inverts hits seen from behind the plane. The bench also checks the result latency and the phase code. These catch a design that lets a rejected triangle run on into the hit-point stage, or that reports a miss late. A back-to-back pair checks that a new request is taken on the edge that delivers the previous hit, and that the tags keep the two results apart.

// File: rtl/tri_isect_pkg.sv
package tri_isect_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEN,
        ST_NUM,
        ST_NN,
        ST_U,
        ST_V
    } isect_st_e;

    localparam logic [1:0] PH_PLANE = 2'd1;
    localparam logic [1:0] PH_BARY  = 2'd2;
    localparam logic [1:0] PH_HIT   = 2'd3;

endpackage

// File: rtl/tri_isect_cross.sv
module tri_isect_cross #(
    parameter int AW = 8,
    parameter int BW = 8
) (
    input  logic [3*AW-1:0]        a_i,
    input  logic [3*BW-1:0]        b_i,
    output logic [3*(AW+BW+1)-1:0] c_o
);
    localparam int OW = AW + BW + 1;

    for (genvar k = 0; k < 3; k++) begin : g_comp
        localparam int I1 = (k + 1) % 3;
        localparam int I2 = (k + 2) % 3;
        assign c_o[k*OW +: OW] =
            OW'($signed(a_i[I1*AW +: AW])) * OW'($signed(b_i[I2*BW +: BW])) -
            OW'($signed(a_i[I2*AW +: AW])) * OW'($signed(b_i[I1*BW +: BW]));
    end
endmodule

// File: rtl/tri_isect_dot3.sv
module tri_isect_dot3 #(
    parameter int AW = 16
) (
    input  logic [3*AW-1:0]        a_i,
    input  logic [3*AW-1:0]        b_i,
    output logic signed [2*AW+1:0] y_o
);
    localparam int YW = 2 * AW + 2;

    logic signed [YW-1:0] prod [3];

    for (genvar k = 0; k < 3; k++) begin : g_mul
        assign prod[k] = YW'($signed(a_i[k*AW +: AW])) * YW'($signed(b_i[k*AW +: AW]));
    end

    assign y_o = prod[0] + prod[1] + prod[2];
endmodule

// File: rtl/tri_isect_hitcalc.sv
module tri_isect_hitcalc #(
    parameter int DW = 35,
    parameter int PW = 72,
    parameter int FB = 8
) (
    input  logic [DW-1:0]    nm_i,
    input  logic [DW-1:0]    ad_i,
    input  logic [PW-1:0]    u_i,
    input  logic [PW-1:0]    v_i,
    input  logic [PW-1:0]    s_i,
    output logic [DW+FB-1:0] t_o,
    output logic [PW+FB-1:0] u_o,
    output logic [PW+FB-1:0] v_o
);
    logic [DW-1:0] ad_safe;
    logic [PW-1:0] s_safe;

    always_comb begin
        ad_safe = (ad_i == '0) ? DW'(1) : ad_i;
        s_safe  = (s_i == '0) ? PW'(1) : s_i;
        t_o = {nm_i, {FB{1'b0}}} / {{FB{1'b0}}, ad_safe};
        u_o = {u_i, {FB{1'b0}}} / {{FB{1'b0}}, s_safe};
        v_o = {v_i, {FB{1'b0}}} / {{FB{1'b0}}, s_safe};
    end
endmodule

// File: rtl/tri_isect.sv
module tri_isect
    import tri_isect_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int FRAC_W  = 8,
    parameter int TAG_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [TAG_W-1:0]          in_tag,
    input  logic [3*COORD_W-1:0]      in_org,
    input  logic [3*COORD_W-1:0]      in_dir,
    input  logic [COORD_W-1:0]        in_tmax,
    input  logic [3*COORD_W-1:0]      in_v0,
    input  logic [3*COORD_W-1:0]      in_e1,
    input  logic [3*COORD_W-1:0]      in_e2,
    output logic                      out_valid,
    output logic [TAG_W-1:0]          out_tag,
    output logic                      out_hit,
    output logic [1:0]                out_phase,
    output logic [COORD_W+FRAC_W-1:0] out_t,
    output logic [FRAC_W:0]           out_u,
    output logic [FRAC_W:0]           out_v
);
    localparam int W   = COORD_W;
    localparam int NW  = 2 * W + 1;
    localparam int CW  = W + NW + 1;
    localparam int DW  = 4 * W + 3;
    localparam int PW  = 2 * DW + 2;
    localparam int TOW = W + FRAC_W;
    localparam int BOW = FRAC_W + 1;
    localparam logic [BOW-1:0] ONE = BOW'(1) << FRAC_W;

    typedef struct packed {
        isect_st_e             st;
        logic [TAG_W-1:0]      tag;
        logic [3*W-1:0]        org;
        logic [3*W-1:0]        dir;
        logic [3*W-1:0]        v0;
        logic [3*W-1:0]        e1;
        logic [3*W-1:0]        e2;
        logic [W-1:0]          tmax;
        logic signed [DW-1:0]  den;
        logic signed [DW-1:0]  nm;
        logic signed [DW-1:0]  ad;
        logic signed [DW-1:0]  nn;
        logic signed [PW-1:0]  uu;
        logic                  p3_vld;
        logic [TAG_W-1:0]      p3_tag;
        logic [DW-1:0]         p3_nm;
        logic [DW-1:0]         p3_ad;
        logic [PW-1:0]         p3_u;
        logic [PW-1:0]         p3_v;
        logic [PW-1:0]         p3_s;
        logic                  o_vld;
        logic [TAG_W-1:0]      o_tag;
        logic                  o_hit;
        logic [1:0]            o_ph;
        logic [TOW-1:0]        o_t;
        logic [BOW-1:0]        o_u;
        logic [BOW-1:0]        o_v;
    } regs_t;

    regs_t r_d, r_q;

    logic [3*NW-1:0]      n_w;
    logic [3*CW-1:0]      c2_w;
    logic [3*CW-1:0]      c1_w;
    logic [3*DW-1:0]      a_op;
    logic [3*DW-1:0]      b_op;
    logic signed [PW-1:0] dot_y;
    logic [DW+FRAC_W-1:0] t_full;
    logic [PW+FRAC_W-1:0] u_full;
    logic [PW+FRAC_W-1:0] v_full;

    // plane normal and the two edge-normal cross products used by phase 2
    tri_isect_cross #(.AW(W),  .BW(W))  u_norm (.a_i(r_q.e1), .b_i(r_q.e2), .c_o(n_w));
    tri_isect_cross #(.AW(W),  .BW(NW)) u_c2   (.a_i(r_q.e2), .b_i(n_w),    .c_o(c2_w));
    tri_isect_cross #(.AW(NW), .BW(W))  u_c1   (.a_i(n_w),    .b_i(r_q.e1), .c_o(c1_w));

    // operand selection for the shared phase-1/2 dot-product unit
    for (genvar k = 0; k < 3; k++) begin : g_ops
        logic signed [DW-1:0] ok, dk, vk, nk, c1k, c2k, relk, qk;
        assign ok   = DW'($signed(r_q.org[k*W +: W]));
        assign dk   = DW'($signed(r_q.dir[k*W +: W]));
        assign vk   = DW'($signed(r_q.v0[k*W +: W]));
        assign nk   = DW'($signed(n_w[k*NW +: NW]));
        assign c1k  = DW'($signed(c1_w[k*CW +: CW]));
        assign c2k  = DW'($signed(c2_w[k*CW +: CW]));
        assign relk = vk - ok;
        assign qk   = ok * r_q.ad + dk * r_q.nm - vk * r_q.ad;
        assign a_op[k*DW +: DW] = (r_q.st == ST_U || r_q.st == ST_V) ? qk : nk;
        assign b_op[k*DW +: DW] = (r_q.st == ST_DEN) ? dk :
                                  (r_q.st == ST_NUM) ? relk :
                                  (r_q.st == ST_NN)  ? nk :
                                  (r_q.st == ST_U)   ? c2k : c1k;
    end

    tri_isect_dot3 #(.AW(DW)) u_dot (.a_i(a_op), .b_i(b_op), .y_o(dot_y));

    tri_isect_hitcalc #(.DW(DW), .PW(PW), .FB(FRAC_W)) u_hit (
        .nm_i(r_q.p3_nm), .ad_i(r_q.p3_ad),
        .u_i(r_q.p3_u), .v_i(r_q.p3_v), .s_i(r_q.p3_s),
        .t_o(t_full), .u_o(u_full), .v_o(v_full)
    );

    logic signed [DW-1:0] dot_lo, ad_c, nm_c, lim_c;
    logic signed [PW-1:0] ss_c;
    logic signed [PW:0]   uv_sum;

    always_comb begin
        r_d        = r_q;
        r_d.o_vld  = 1'b0;
        r_d.p3_vld = 1'b0;
        dot_lo     = dot_y[DW-1:0];
        ad_c       = (r_q.den < 0) ? -r_q.den : r_q.den;
        nm_c       = (r_q.den < 0) ? -dot_lo : dot_lo;
        lim_c      = $signed(DW'({1'b0, r_q.tmax})) * ad_c;
        ss_c       = PW'(r_q.nn) * PW'(r_q.ad);
        uv_sum     = (PW+1)'(r_q.uu) + (PW+1)'(dot_y);

        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.tag  = in_tag;
                    r_d.org  = in_org;
                    r_d.dir  = in_dir;
                    r_d.tmax = in_tmax;
                    r_d.v0   = in_v0;
                    r_d.e1   = in_e1;
                    r_d.e2   = in_e2;
                    r_d.st   = ST_DEN;
                end
            end
            ST_DEN: begin
                r_d.den = dot_lo;
                r_d.st  = ST_NUM;
            end
            ST_NUM: begin
                if (r_q.den == '0 || nm_c < 0 || nm_c >= lim_c) begin
                    r_d.o_vld = 1'b1;
                    r_d.o_tag = r_q.tag;
                    r_d.o_hit = 1'b0;
                    r_d.o_ph  = PH_PLANE;
                    r_d.o_t   = '0;
                    r_d.o_u   = '0;
                    r_d.o_v   = '0;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.nm = nm_c;
                    r_d.ad = ad_c;
                    r_d.st = ST_NN;
                end
            end
            ST_NN: begin
                r_d.nn = dot_lo;
                r_d.st = ST_U;
            end
            ST_U: begin
                r_d.uu = dot_y;
                r_d.st = ST_V;
            end
            ST_V: begin
                if (r_q.uu < 0 || dot_y < 0 || uv_sum > (PW+1)'(ss_c)) begin
                    r_d.o_vld = 1'b1;
                    r_d.o_tag = r_q.tag;
                    r_d.o_hit = 1'b0;
                    r_d.o_ph  = PH_BARY;
                    r_d.o_t   = '0;
                    r_d.o_u   = '0;
                    r_d.o_v   = '0;
                end else begin
                    r_d.p3_vld = 1'b1;
                    r_d.p3_tag = r_q.tag;
                    r_d.p3_nm  = r_q.nm;
                    r_d.p3_ad  = r_q.ad;
                    r_d.p3_u   = r_q.uu;
                    r_d.p3_v   = dot_y;
                    r_d.p3_s   = ss_c;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (r_q.p3_vld) begin
            r_d.o_vld = 1'b1;
            r_d.o_tag = r_q.p3_tag;
            r_d.o_hit = 1'b1;
            r_d.o_ph  = PH_HIT;
            r_d.o_t   = t_full[TOW-1:0];
            r_d.o_u   = u_full[BOW-1:0];
            r_d.o_v   = v_full[BOW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready  = (r_q.st == ST_IDLE);
    assign out_valid = r_q.o_vld;
    assign out_tag   = r_q.o_tag;
    assign out_hit   = r_q.o_hit;
    assign out_phase = r_q.o_ph;
    assign out_t     = r_q.o_t;
    assign out_u     = r_q.o_u;
    assign out_v     = r_q.o_v;

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    a_r7_plane_miss_from_num: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_phase == PH_PLANE |-> $past(r_q.st) == ST_NUM);

    a_r5_hitstage_after_bary: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.p3_vld |-> $past(r_q.st) == ST_V);

    a_r6_quotients_fit: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.p3_vld |-> t_full[DW+FRAC_W-1:TOW] == '0 &&
                       u_full <= (PW+FRAC_W)'(ONE) && v_full <= (PW+FRAC_W)'(ONE));

    a_r6_weight_sum: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hit |-> (BOW+1)'(out_u) + (BOW+1)'(out_v) <= (BOW+1)'(ONE));

    a_r8_no_adjacent_results: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: tb/sim_tri_isect.sv
`timescale 1ns/1ps
module sim_tri_isect;
    localparam int W  = 8;
    localparam int FB = 8;
    localparam int TW = 4;
    localparam int VW = 3 * W;

    typedef logic signed [127:0] big_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [TW-1:0] in_tag = '0;
    logic [VW-1:0] in_org = '0, in_dir = '0, in_v0 = '0, in_e1 = '0, in_e2 = '0;
    logic [W-1:0] in_tmax = '0;
    logic out_valid, out_hit;
    logic [TW-1:0] out_tag;
    logic [1:0] out_phase;
    logic [W+FB-1:0] out_t;
    logic [FB:0] out_u, out_v;

    int checks = 0;
    int errors = 0;
    logic [TW-1:0] tag_ctr = '0;

    always #4 clk = ~clk;

    tri_isect #(.COORD_W(W), .FRAC_W(FB), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_org(in_org), .in_dir(in_dir), .in_tmax(in_tmax),
        .in_v0(in_v0), .in_e1(in_e1), .in_e2(in_e2),
        .out_valid(out_valid), .out_tag(out_tag), .out_hit(out_hit),
        .out_phase(out_phase), .out_t(out_t), .out_u(out_u), .out_v(out_v)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] pk(input int x, input int y, input int z);
        logic [31:0] a, b, c;
        a = x; b = y; c = z;
        return {c[W-1:0], b[W-1:0], a[W-1:0]};
    endfunction

    function automatic big_t cp(input logic [VW-1:0] vec, input int k);
        return big_t'($signed(vec[k*W +: W]));
    endfunction

    function automatic int rr(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // behavioural model: plane crossing, then barycentric weights via n.(Q x e2), n.(e1 x Q)
    function automatic void model(input logic [VW-1:0] o, d, p0, a1, a2, input int tmax,
                                  output int ph, output longint t, output longint u, output longint v);
        big_t vo[3], vd[3], vp[3], va[3], vb[3], n[3], q[3], x1[3], x2[3];
        big_t den, num, nm, ad, uu, vv, ss, nn;
        for (int k = 0; k < 3; k++) begin
            vo[k] = cp(o, k); vd[k] = cp(d, k); vp[k] = cp(p0, k);
            va[k] = cp(a1, k); vb[k] = cp(a2, k);
        end
        n[0] = va[1]*vb[2] - va[2]*vb[1];
        n[1] = va[2]*vb[0] - va[0]*vb[2];
        n[2] = va[0]*vb[1] - va[1]*vb[0];
        den = 0; num = 0; nn = 0;
        for (int k = 0; k < 3; k++) begin
            den += n[k]*vd[k];
            num += n[k]*(vp[k] - vo[k]);
            nn  += n[k]*n[k];
        end
        t = 0; u = 0; v = 0;
        if (den == 0) begin ph = 1; return; end
        ad = (den < 0) ? -den : den;
        nm = (den < 0) ? -num : num;
        if (nm < 0 || nm >= big_t'(tmax) * ad) begin ph = 1; return; end
        for (int k = 0; k < 3; k++) q[k] = vo[k]*ad + vd[k]*nm - vp[k]*ad;
        x2[0] = q[1]*vb[2] - q[2]*vb[1];
        x2[1] = q[2]*vb[0] - q[0]*vb[2];
        x2[2] = q[0]*vb[1] - q[1]*vb[0];
        x1[0] = va[1]*q[2] - va[2]*q[1];
        x1[1] = va[2]*q[0] - va[0]*q[2];
        x1[2] = va[0]*q[1] - va[1]*q[0];
        uu = 0; vv = 0;
        for (int k = 0; k < 3; k++) begin
            uu += n[k]*x2[k];
            vv += n[k]*x1[k];
        end
        ss = nn * ad;
        if (uu < 0 || vv < 0 || uu + vv > ss) begin ph = 2; return; end
        ph = 3;
        t = longint'((nm <<< FB) / ad);
        u = longint'((uu <<< FB) / ss);
        v = longint'((vv <<< FB) / ss);
    endfunction

    task automatic drive(input logic [VW-1:0] o, d, p0, a1, a2, input int tmax, input logic [TW-1:0] tg);
        in_valid = 1'b1; in_tag = tg; in_org = o; in_dir = d;
        in_v0 = p0; in_e1 = a1; in_e2 = a2; in_tmax = W'(tmax);
    endtask

    task automatic run_one(input string req, input logic [VW-1:0] o, d, p0, a1, a2, input int tmax);
        int ph, lat, elat;
        longint et, eu, ev;
        logic [TW-1:0] tg;
        tg = tag_ctr; tag_ctr++;
        model(o, d, p0, a1, a2, tmax, ph, et, eu, ev);
        @(negedge clk);
        drive(o, d, p0, a1, a2, tmax, tg);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R1"}, "ready after accept", longint'(in_ready), 0);
        lat = 0;
        while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
        elat = (ph == 1) ? 2 : (ph == 2) ? 5 : 6;
        chk({req, " R7"}, "latency", lat, elat);
        chk({req, " R3 R4 R5"}, "phase", longint'(out_phase), ph);
        chk({req, " R9"}, "hit", longint'(out_hit), (ph == 3) ? 1 : 0);
        chk({req, " R9"}, "tag", longint'(out_tag), longint'(tg));
        chk({req, " R6 R9"}, "t", longint'(out_t), et);
        chk({req, " R6 R9"}, "u", longint'(out_u), eu);
        chk({req, " R6 R9"}, "v", longint'(out_v), ev);
        @(negedge clk);
        chk({req, " R7"}, "single-cycle result", longint'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] tv0, te1, te2;
        int lat;
        void'($urandom(32'd20240611));
        tv0 = pk(0, 0, 0); te1 = pk(4, 0, 0); te2 = pk(0, 4, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "ready after reset", longint'(in_ready), 1);
        chk("R2", "valid after reset", longint'(out_valid), 0);

        // directed corner cases on a right triangle in z=0 with n=(0,0,16), packing per R10
        run_one("R6 R10 centre", pk(1, 1, -2), pk(0, 0, 1), tv0, te1, te2, 3);
        chk("R6", "centre t literal", longint'(out_t), 512);
        run_one("R3 parallel", pk(1, 1, -2), pk(1, 0, 0), tv0, te1, te2, 3);
        run_one("R4 behind", pk(1, 1, 2), pk(0, 0, 1), tv0, te1, te2, 3);
        run_one("R4 at tmax", pk(1, 1, -2), pk(0, 0, 1), tv0, te1, te2, 2);
        run_one("R4 t zero", pk(1, 1, 0), pk(0, 0, 1), tv0, te1, te2, 1);
        run_one("R6 negative den", pk(1, 1, 2), pk(0, 0, -1), tv0, te1, te2, 3);
        run_one("R5 edge u0", pk(0, 2, -1), pk(0, 0, 1), tv0, te1, te2, 2);
        chk("R5", "edge v literal", longint'(out_v), 128);
        run_one("R5 hypotenuse", pk(2, 2, -1), pk(0, 0, 1), tv0, te1, te2, 2);
        run_one("R5 vertex", pk(4, 0, -1), pk(0, 0, 1), tv0, te1, te2, 2);
        chk("R5", "vertex u literal", longint'(out_u), 256);
        run_one("R5 outside sum", pk(3, 3, -1), pk(0, 0, 1), tv0, te1, te2, 2);
        run_one("R5 outside neg", pk(-1, 1, -1), pk(0, 0, 1), tv0, te1, te2, 2);

        // R8: next request accepted on the edge that delivers the hit
        @(negedge clk);
        drive(pk(1, 1, -2), pk(0, 0, 1), tv0, te1, te2, 3, 4'hA);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!in_ready && lat < 20) begin @(negedge clk); lat++; end
        chk("R8", "ready return edge", lat, 5);
        drive(pk(1, 1, -2), pk(1, 0, 0), tv0, te1, te2, 3, 4'h5);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "hit during accept", longint'(out_valid), 1);
        chk("R8", "hit tag", longint'(out_tag), 10);
        chk("R8", "hit flag", longint'(out_hit), 1);
        chk("R8", "busy with next", longint'(in_ready), 0);
        @(negedge clk);
        chk("R8", "gap between results", longint'(out_valid), 0);
        @(negedge clk);
        chk("R8", "second result", longint'(out_valid), 1);
        chk("R8 R9", "second tag", longint'(out_tag), 5);
        chk("R8 R3", "second phase", longint'(out_phase), 1);

        // constrained random: aimed rays and unconstrained full-range rays
        for (int i = 0; i < 400; i++) begin
            int o[3], d[3], p[3], a[3], b[3], fa, fb, tm;
            for (int k = 0; k < 3; k++) begin
                p[k] = rr(-20, 20); a[k] = rr(-20, 20); b[k] = rr(-20, 20);
                o[k] = rr(-40, 40);
            end
            if (i % 2 == 0) begin
                fa = rr(0, 16); fb = rr(0, 16 - fa);
                for (int k = 0; k < 3; k++) d[k] = p[k] + (fa*a[k] + fb*b[k]) / 16 - o[k];
                if (d[0] == 0 && d[1] == 0 && d[2] == 0) d[0] = 1;
                tm = rr(0, 4);
            end else begin
                for (int k = 0; k < 3; k++) begin
                    p[k] = rr(-128, 127); a[k] = rr(-128, 127); b[k] = rr(-128, 127);
                    o[k] = rr(-128, 127); d[k] = rr(-128, 127);
                end
                tm = rr(0, 255);
            end
            run_one("random", pk(o[0], o[1], o[2]), pk(d[0], d[1], d[2]),
                    pk(p[0], p[1], p[2]), pk(a[0], a[1], a[2]), pk(b[0], b[1], b[2]), tm);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule